// File: doc/BRIEF.md
# Illumination Window Slot Sequencer

This block turns a single fast system clock into a slow, framed illumination gate. Two modulo counters in series form a prescaler chain. With the default divisors of 100 and 625 on a 10 MHz clock, the chain yields a slot tick every 6.25 ms. The tick advances a small slot counter. A frame is one full cycle of that counter, so eight slots of 6.25 ms make a 50 ms frame.

The slot number feeds a one-of-N decoder whose selected line is driven low and whose other lines stay high. The lowest `ON_SLOTS` decoder lines are ANDed together to form the gate. The gate is therefore active-low for the first `ON_SLOTS` slots of each frame, which is 31.25 ms of every 50 ms with the defaults. The window length comes from how many decoder lines are combined, not from a width register.

Everything runs on the one clock. The prescaler stages use clock enables, and none of them produces a derived clock. A one-clock frame-start strobe marks each wrap of the slot counter back to zero.

Top module: `illum_window_seq`

## Requirements
- R1: `slot_tick` is high for exactly one clock once every `PRE_A_DIV*PRE_B_DIV` clocks. After reset is released, the first tick occurs in the cycle reached by `PRE_A_DIV*PRE_B_DIV-1` rising edges.
- R2: `slot_idx` increases by one on the clock edge that ends a `slot_tick` cycle and holds its value at every other edge. It wraps from its maximum value (7 for the default 3-bit counter) back to 0, so a frame lasts `2**SLOT_W` slots.
- R3: `illum_n` is 0 while `slot_idx` is below `ON_SLOTS` and 1 otherwise. With the defaults it is low in slots 0 to 4 and high in slots 5 to 7. It is therefore low for `ON_SLOTS*PRE_A_DIV*PRE_B_DIV` clocks of each frame.
- R4: In `slot_sel_n`, exactly one bit is 0, and that bit is the one at position `slot_idx` (bit i belongs to slot i). All other bits are 1.
- R5: `frame_start` is 1 for exactly one clock, in the first cycle in which `slot_idx` reads 0 after having read its maximum value. It is 0 at all other times, including the frame that begins at reset.
- R6: While `rst_n` is 0, and in the first cycle after it is released, `slot_idx` is 0, `slot_tick` is 0, `frame_start` is 0, `illum_n` is 0 and `slot_sel_n` has only bit 0 low. Reset clears both prescaler stages, so timing restarts from the start of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (10 MHz with the default divisors) |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_tick | output | 1 | One-clock pulse at the last clock of each slot |
| slot_idx | output | SLOT_W | Current slot number |
| slot_sel_n | output | 2**SLOT_W | Active-low one-of-N decode of the slot number |
| illum_n | output | 1 | Illumination gate, low during slots 0 to ON_SLOTS-1 |
| frame_start | output | 1 | One-clock strobe when the slot number wraps to 0 |

## Verification
The bench drives reset at random points inside a slot and inside a frame, so it catches any prescaler stage that fails to clear. Such a design would place the first tick early and shift every slot after it. It runs across several frame wraps to look for three faults: a strobe that fires on the reset frame, a slot counter that stops at its maximum, and a gate window that is one slot too long or too short because the wrong set of decoder lines was combined. It also measures the tick spacing, which exposes an off-by-one in either divisor.

// File: rtl/illum_pkg.sv
package illum_pkg;

   // Counter width for a modulo-n counter, at least one bit.
   function automatic int cnt_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/illum_mod_counter.sv
module illum_mod_counter #(
   parameter int DIV = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic term
);
   localparam int CNT_W = illum_pkg::cnt_width(DIV);

   if (DIV < 1) begin : g_bad_div
      $error("illum_mod_counter: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_pass
      // Divide-by-one: every enable is a terminal count.
      assign term = en;
   end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      logic             at_top;

      assign at_top = (cnt_q == CNT_W'(DIV - 1));
      assign term   = en && at_top;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (en) begin
            cnt_q <= at_top ? '0 : cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/illum_onehot_dec_n.sv
module illum_onehot_dec_n #(
   parameter int SEL_W = 3
) (
   input  logic [SEL_W-1:0]      sel,
   output logic [(1<<SEL_W)-1:0] dec_n
);
   localparam int N_OUT = 1 << SEL_W;

   if (SEL_W < 1) begin : g_bad_w
      $error("illum_onehot_dec_n: SEL_W must be at least 1");
   end

   for (genvar i = 0; i < N_OUT; i++) begin : g_line
      assign dec_n[i] = (sel != SEL_W'(i));
   end

endmodule

// File: rtl/illum_window_seq.sv
module illum_window_seq #(
   parameter int PRE_A_DIV = 100,
   parameter int PRE_B_DIV = 625,
   parameter int SLOT_W    = 3,
   parameter int ON_SLOTS  = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   output logic                   slot_tick,
   output logic [SLOT_W-1:0]      slot_idx,
   output logic [(1<<SLOT_W)-1:0] slot_sel_n,
   output logic                   illum_n,
   output logic                   frame_start
);
   localparam int          N_SLOT   = 1 << SLOT_W;
   localparam logic [SLOT_W-1:0] SLOT_MAX = SLOT_W'(N_SLOT - 1);

   if (ON_SLOTS < 1 || ON_SLOTS >= N_SLOT) begin : g_bad_on
      $error("illum_window_seq: ON_SLOTS must lie in 1..2**SLOT_W-1");
   end
   if (PRE_A_DIV < 1 || PRE_B_DIV < 1) begin : g_bad_pre
      $error("illum_window_seq: prescaler divisors must be at least 1");
   end

   logic stage_a_term;
   logic tick;
   logic [SLOT_W-1:0] slot_q;
   logic frame_q;

   illum_mod_counter #(.DIV(PRE_A_DIV)) u_pre_a (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (1'b1),
      .term  (stage_a_term)
   );

   illum_mod_counter #(.DIV(PRE_B_DIV)) u_pre_b (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (stage_a_term),
      .term  (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q  <= '0;
         frame_q <= 1'b0;
      end else begin
         frame_q <= tick && (slot_q == SLOT_MAX);
         if (tick) begin
            slot_q <= slot_q + 1'b1;
         end
      end
   end

   illum_onehot_dec_n #(.SEL_W(SLOT_W)) u_dec (
      .sel   (slot_q),
      .dec_n (slot_sel_n)
   );

   // Gate is the AND of the active-low lines of the window slots.
   assign illum_n     = &slot_sel_n[ON_SLOTS-1:0];
   assign slot_tick   = tick;
   assign slot_idx    = slot_q;
   assign frame_start = frame_q;

endmodule

// File: rtl/illum_window_seq_chk.sv
module illum_window_seq_chk #(
   parameter int PRE_A_DIV = 100,
   parameter int PRE_B_DIV = 625,
   parameter int SLOT_W    = 3,
   parameter int ON_SLOTS  = 5
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   slot_tick,
   input logic [SLOT_W-1:0]      slot_idx,
   input logic [(1<<SLOT_W)-1:0] slot_sel_n,
   input logic                   illum_n,
   input logic                   frame_start
);
   localparam int N_SLOT   = 1 << SLOT_W;
   localparam int SLOT_LEN = PRE_A_DIV * PRE_B_DIV;
   localparam logic [SLOT_W-1:0] SLOT_MAX = SLOT_W'(N_SLOT - 1);

   int gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         gap_q <= 0;
      else if (slot_tick) gap_q <= 0;
      else                gap_q <= gap_q + 1;
   end

   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      slot_tick |-> (gap_q == SLOT_LEN - 1));                                  // R1
   AST_TICK_NOT_LATE: assert property (@(posedge clk) disable iff (!rst_n)
      (gap_q == SLOT_LEN - 1) |-> slot_tick);                                  // R1
   AST_SLOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_tick |=> $stable(slot_idx));                                       // R2
   AST_SLOT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      slot_tick |=> (slot_idx == SLOT_W'($past(slot_idx) + 1'b1)));            // R2
   AST_GATE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      illum_n == (int'(slot_idx) >= ON_SLOTS));                                // R3
   AST_DECODE_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(slot_sel_n) == N_SLOT - 1) && !slot_sel_n[slot_idx]);        // R4
   AST_FRAME_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (slot_idx == '0) && ($past(slot_idx) == SLOT_MAX));      // R5
   AST_FRAME_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start);                                           // R5
   AST_RESET_CLEARS: assert property (@(posedge clk)
      !rst_n |=> (slot_idx == '0) && !frame_start && !slot_tick);              // R6

endmodule

bind illum_window_seq illum_window_seq_chk #(
   .PRE_A_DIV (PRE_A_DIV),
   .PRE_B_DIV (PRE_B_DIV),
   .SLOT_W    (SLOT_W),
   .ON_SLOTS  (ON_SLOTS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .slot_tick   (slot_tick),
   .slot_idx    (slot_idx),
   .slot_sel_n  (slot_sel_n),
   .illum_n     (illum_n),
   .frame_start (frame_start)
);

// File: tb/sim_illum_window_seq.sv
module sim_illum_window_seq;
   localparam int CLK_PERIOD = 100;
   localparam int PA     = 4;
   localparam int PB     = 3;
   localparam int SW     = 3;
   localparam int ON     = 5;
   localparam int NS     = 1 << SW;
   localparam int P      = PA * PB;
   localparam int FRAME  = P * NS;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          slot_tick;
   logic [SW-1:0] slot_idx;
   logic [NS-1:0] slot_sel_n;
   logic          illum_n;
   logic          frame_start;

   int checks = 0;
   int failures = 0;
   int c = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   illum_window_seq #(.PRE_A_DIV(PA), .PRE_B_DIV(PB), .SLOT_W(SW), .ON_SLOTS(ON)) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .slot_tick   (slot_tick),
      .slot_idx    (slot_idx),
      .slot_sel_n  (slot_sel_n),
      .illum_n     (illum_n),
      .frame_start (frame_start)
   );

   function automatic int exp_slot(input int n);
      return (n / P) % NS;
   endfunction
   function automatic int exp_tick(input int n);
      return ((n % P) == P - 1) ? 1 : 0;
   endfunction
   function automatic int exp_frame(input int n);
      return (n > 0 && (n % FRAME) == 0) ? 1 : 0;
   endfunction
   function automatic int exp_gate(input int n);
      return (exp_slot(n) >= ON) ? 1 : 0;
   endfunction
   function automatic int exp_sel(input int n);
      return int'(~(NS'(1) << exp_slot(n)) & {NS{1'b1}});
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s cycle=%0d actual=%0d expected=%0d", req, c, act, exp);
      end
   endtask

   task automatic check_all();
      chk("R1 tick",  int'(slot_tick),   exp_tick(c));
      chk("R2 slot",  int'(slot_idx),    exp_slot(c));
      chk("R3 gate",  int'(illum_n),     exp_gate(c));
      chk("R4 decode", int'(slot_sel_n), exp_sel(c));
      chk("R5 frame", int'(frame_start), exp_frame(c));
   endtask

   task automatic do_reset(input int hold);
      @(negedge clk);
      rst_n = 1'b0;
      c = 0;
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         // R6: state while reset is held
         chk("R6 slot in reset",  int'(slot_idx),    0);
         chk("R6 gate in reset",  int'(illum_n),     0);
         chk("R6 frame in reset", int'(frame_start), 0);
      end
      rst_n = 1'b1;
      check_all();
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         c++;
         @(negedge clk);
         check_all();
      end
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stim
      int low_cnt;
      void'($urandom(32'h1ee7_5eed));
      // Directed: reset, then three whole frames (R1, R2, R5 wrap).
      do_reset(3);
      run(3 * FRAME + 5);

      // Directed: count gate-low clocks over one frame (R3).
      do_reset(2);
      low_cnt = 0;
      for (int i = 0; i < FRAME; i++) begin
         if (!illum_n) low_cnt++;
         @(posedge clk);
         c++;
         @(negedge clk);
      end
      chk("R3 low clocks per frame", low_cnt, ON * P);

      // Directed: reset in the cycle before a frame wrap (R6, R5).
      run(FRAME - 2);
      do_reset(1);
      run(FRAME + 2);

      // Random: reset at arbitrary points within slots and frames.
      for (int k = 0; k < 40; k++) begin
         do_reset(1 + int'($urandom_range(4, 0)));
         run(int'($urandom_range(2 * FRAME + 30, 1)));
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule